// File: doc/BRIEF.md
# Boot-Overlay Memory Bank Mapper

This block decodes the memory and I/O cycles of an 8-bit Z80-style CPU bus and steers them to a 32 KiB ROM and a 128 KiB RAM. It drives the ROM chip select, the RAM chip select and the top RAM address bit. The top RAM address bit picks one of two 64 KiB RAM banks.

Two control flip-flops set the memory map. The overlay flip-flop puts the ROM over the lower half of the map after reset. Boot code clears it with a write to I/O port 0x38, and from then on RAM fills the whole 64 KiB space. The bank flip-flop is loaded by writes to I/O port 0x30. It swaps the entire visible RAM range between the two banks, because no window is shared between them.

The mapper has no configuration inputs. The port addresses are fixed. All bus strobes are active-high at this block's pins. Port writes take effect on the rising clock edge on which the write strobes are seen, and the chip selects follow the address combinationally.

Top module: `bank_mapper`

## Requirements
- R1: After synchronous reset the overlay is on and bank 0 is selected. A memory cycle at 0x0000 asserts rom_cs, and one at 0x8000 asserts ram_cs with ram_a16 = 0.
- R2: rom_cs is 1 exactly when mreq = 1, addr[15] = 0 and the overlay is on.
- R3: ram_cs is 1 exactly when mreq = 1 and rom_cs = 0. rom_cs and ram_cs are never 1 together, and both are 0 while mreq = 0.
- R4: ram_a16 always equals the bank flip-flop, where 0 is bank 0 and 1 is bank 1.
- R5: An I/O write to port 0x30 loads data[0] into the bank flip-flop on the clock edge where it is seen. data[7:1] are ignored.
- R6: Any I/O write to port 0x38 turns the overlay off, whatever the data value. Only reset turns it back on.
- R7: Port decoding compares only addr[7:0]. For example, 0xA530 acts as port 0x30 and 0x1238 acts as port 0x38.
- R8: A port write counts only when iorq = 1, wr = 1 and m1 = 0. Cycles with m1 = 1, cycles missing iorq or wr, and writes to any other low address byte leave both flip-flops unchanged.
- R9: Memory write cycles (mreq = 1, wr = 1, iorq = 0) never change either flip-flop, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active-high |
| addr | input | 16 | CPU address bus |
| data | input | 8 | CPU data bus, sampled on port writes |
| mreq | input | 1 | Memory request, active-high |
| iorq | input | 1 | I/O request, active-high |
| wr | input | 1 | Write strobe, active-high |
| m1 | input | 1 | Opcode fetch / interrupt acknowledge, active-high |
| rom_cs | output | 1 | ROM chip select, active-high |
| ram_cs | output | 1 | RAM chip select, active-high |
| ram_a16 | output | 1 | RAM address bit 16 (bank) |

## Verification
A wrong overlay bit shows on the very next memory cycle below 0x8000: the select moves from ROM to RAM or the reverse. A wrong bank bit shows on ram_a16 at once and on every later cycle, because nothing else ever rewrites it. The bench sweeps every upper address byte in each reachable map state, so a decode error at any 256-byte boundary is seen. Writes that should be ignored are each followed at once by a memory cycle that reads the state back through the selects.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int PORT_W   = 8;
    localparam int N_PORTS  = 2;

    localparam logic [PORT_W-1:0] PORT_BANK  = 8'h30;
    localparam logic [PORT_W-1:0] PORT_ROMOFF = 8'h38;

    typedef enum logic [0:0] {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_e;

    typedef struct packed {
        logic  rom_on;
        bank_e bank;
    } map_state_t;

    typedef struct packed {
        logic bank_load;
        logic rom_kill;
    } port_cmd_t;

    localparam map_state_t MAP_RESET = '{rom_on: 1'b1, bank: BANK_LO};

    function automatic logic is_io_write(input logic iorq, input logic wr, input logic m1);
        return iorq & wr & ~m1;
    endfunction

    function automatic logic in_rom_half(input logic [ADDR_W-1:0] a);
        return ~a[ADDR_W-1];
    endfunction

endpackage

// File: rtl/mbm_port_decode.sv
module mbm_port_decode
    import mbm_pkg::*;
(
    input  logic [PORT_W-1:0] port_lo,
    input  logic              iorq,
    input  logic              wr,
    input  logic              m1,
    output port_cmd_t         cmd
);
    localparam logic [PORT_W-1:0] PORT_TABLE [N_PORTS] = '{PORT_BANK, PORT_ROMOFF};

    logic             io_wr;
    logic [N_PORTS-1:0] hit;

    assign io_wr = is_io_write(iorq, wr, m1);

    for (genvar g = 0; g < N_PORTS; g++) begin : g_cmp
        assign hit[g] = io_wr && (port_lo == PORT_TABLE[g]);
    end

    always_comb begin
        cmd           = '0;
        cmd.bank_load = hit[0];
        cmd.rom_kill  = hit[1];
    end
endmodule

// File: rtl/mbm_ctrl_regs.sv
module mbm_ctrl_regs
    import mbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_cmd_t  cmd,
    input  logic       bank_bit,
    output map_state_t state
);
    map_state_t nxt;

    always_comb begin
        nxt = state;
        if (cmd.bank_load) nxt.bank   = bank_e'(bank_bit);
        if (cmd.rom_kill)  nxt.rom_on = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= MAP_RESET;
        else     state <= nxt;
    end
endmodule

// File: rtl/mbm_select.sv
module mbm_select
    import mbm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq,
    input  map_state_t        state,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic              ram_a16
);
    logic rom_claim;

    assign rom_claim = state.rom_on & in_rom_half(addr);
    assign rom_cs    = mreq & rom_claim;
    assign ram_cs    = mreq & ~rom_claim;
    assign ram_a16   = state.bank;
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import mbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              mreq,
    input  logic              iorq,
    input  logic              wr,
    input  logic              m1,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic              ram_a16
);
    port_cmd_t  cmd;
    map_state_t state;
    logic       rom_on_q;
    logic       bank_q;
    logic [DATA_W-2:0] data_hi_unused;

    assign data_hi_unused = data[DATA_W-1:1];

    mbm_port_decode u_dec (
        .port_lo (addr[PORT_W-1:0]),
        .iorq    (iorq),
        .wr      (wr),
        .m1      (m1),
        .cmd     (cmd)
    );

    mbm_ctrl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .bank_bit (data[0]),
        .state    (state)
    );

    mbm_select u_sel (
        .addr    (addr),
        .mreq    (mreq),
        .state   (state),
        .rom_cs  (rom_cs),
        .ram_cs  (ram_cs),
        .ram_a16 (ram_a16)
    );

    assign rom_on_q = state.rom_on;
    assign bank_q   = state.bank;
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] addr,
    input logic [7:0]  data,
    input logic        mreq,
    input logic        iorq,
    input logic        wr,
    input logic        m1,
    input logic        rom_cs,
    input logic        ram_cs,
    input logic        ram_a16,
    input logic        rom_on_q,
    input logic        bank_q
);
    logic wr_bank, wr_rom;
    assign wr_bank = iorq && wr && !m1 && (addr[7:0] == 8'h30);
    assign wr_rom  = iorq && wr && !m1 && (addr[7:0] == 8'h38);

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(rom_cs && ram_cs)); // R3
    AST_ROM_WINDOW:    assert property (@(posedge clk) disable iff (rst) rom_cs |-> (mreq && !addr[15] && rom_on_q)); // R2
    AST_RAM_FILL:      assert property (@(posedge clk) disable iff (rst) (mreq && !rom_cs) |-> ram_cs); // R3
    AST_NO_SEL_IDLE:   assert property (@(posedge clk) disable iff (rst) !mreq |-> (!rom_cs && !ram_cs)); // R3
    AST_A16_TRACK:     assert property (@(posedge clk) disable iff (rst) ram_a16 == bank_q); // R4
    AST_BANK_LOAD:     assert property (@(posedge clk) disable iff (rst) wr_bank |=> (bank_q == $past(data[0]))); // R5
    AST_ROM_CLEAR:     assert property (@(posedge clk) disable iff (rst) wr_rom |=> !rom_on_q); // R6
    AST_ROM_STICKY:    assert property (@(posedge clk) disable iff (rst) !rom_on_q |=> !rom_on_q); // R6
    AST_M1_HOLD:       assert property (@(posedge clk) disable iff (rst) m1 |=> ($stable(bank_q) && $stable(rom_on_q))); // R8
    AST_MEM_HOLD:      assert property (@(posedge clk) disable iff (rst) (!iorq) |=> ($stable(bank_q) && $stable(rom_on_q))); // R9
endmodule

bind bank_mapper mbm_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .data     (data),
    .mreq     (mreq),
    .iorq     (iorq),
    .wr       (wr),
    .m1       (m1),
    .rom_cs   (rom_cs),
    .ram_cs   (ram_cs),
    .ram_a16  (ram_a16),
    .rom_on_q (rom_on_q),
    .bank_q   (bank_q)
);

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic        mreq = 1'b0, iorq = 1'b0, wr = 1'b0, m1 = 1'b0;
    logic        rom_cs, ram_cs, ram_a16;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bank_mapper dut (
        .clk(clk), .rst(rst), .addr(addr), .data(data),
        .mreq(mreq), .iorq(iorq), .wr(wr), .m1(m1),
        .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_a16(ram_a16)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One memory cycle; compare selects against the modelled map state.
    task automatic mem_probe(input string req, input logic [15:0] a,
                             input logic rom_on, input logic bank);
        logic exp_rom;
        @(negedge clk);
        addr = a; mreq = 1'b1; iorq = 1'b0; wr = 1'b0; m1 = 1'b0;
        #1;
        exp_rom = rom_on && (a < 16'h8000);
        chk(req, $sformatf("rom_cs @%h", a), rom_cs, exp_rom);
        chk(req, $sformatf("ram_cs @%h", a), ram_cs, !exp_rom);
        chk(req, $sformatf("ram_a16 @%h", a), ram_a16, bank);
        mreq = 1'b0;
        #1;
        chk(req, "idle selects", rom_cs | ram_cs, 1'b0);
    endtask

    task automatic sweep(input string req, input logic rom_on, input logic bank);
        for (int hi = 0; hi < 256; hi++)
            mem_probe(req, {hi[7:0], 8'hA5}, rom_on, bank);
    endtask

    task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                             input logic q_mreq, input logic q_iorq,
                             input logic q_wr, input logic q_m1);
        @(negedge clk);
        addr = a; data = d; mreq = q_mreq; iorq = q_iorq; wr = q_wr; m1 = q_m1;
        @(negedge clk);
        mreq = 1'b0; iorq = 1'b0; wr = 1'b0; m1 = 1'b0; data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state seen at the ports
        mem_probe("R1", 16'h0000, 1'b1, 1'b0);
        mem_probe("R1", 16'h8000, 1'b1, 1'b0);
        // R2 R3 full sweep with overlay on, bank 0
        sweep("R2", 1'b1, 1'b0);

        // R5 R7: aliased bank port, upper data bits ignored
        bus_cycle(16'hA530, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0);
        mem_probe("R5", 16'h8000, 1'b1, 1'b1);
        bus_cycle(16'h0030, 8'hFE, 1'b0, 1'b1, 1'b1, 1'b0);
        mem_probe("R5", 16'hFFFF, 1'b1, 1'b0);
        bus_cycle(16'h7730, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0);
        mem_probe("R7", 16'h4000, 1'b1, 1'b1);
        // R4 sweep with bank 1
        sweep("R4", 1'b1, 1'b1);

        // R8: ignored cycles, each read back at once
        bus_cycle(16'h0030, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
        mem_probe("R8 m1", 16'h8000, 1'b1, 1'b1);
        bus_cycle(16'h0038, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
        mem_probe("R8 m1", 16'h0100, 1'b1, 1'b1);
        bus_cycle(16'h0030, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        mem_probe("R8 no-wr", 16'h8000, 1'b1, 1'b1);
        bus_cycle(16'h0038, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        mem_probe("R8 no-iorq", 16'h0100, 1'b1, 1'b1);
        for (int p = 0; p < 256; p++) begin
            if (p != 8'h30 && p != 8'h38) begin
                bus_cycle({8'h30, p[7:0]}, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
                mem_probe("R8 port", 16'h0000, 1'b1, 1'b1);
            end
        end

        // R9: memory writes at the port addresses
        bus_cycle(16'h0030, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
        mem_probe("R9", 16'h8000, 1'b1, 1'b1);
        bus_cycle(16'h0038, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
        mem_probe("R9", 16'h0038, 1'b1, 1'b1);

        // R6: overlay off with nonzero data, then sticky
        bus_cycle(16'h1238, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0);
        mem_probe("R6", 16'h0000, 1'b0, 1'b1);
        sweep("R6", 1'b0, 1'b1);
        bus_cycle(16'h0038, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        mem_probe("R6 sticky", 16'h7FFF, 1'b0, 1'b1);
        bus_cycle(16'h0030, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
        mem_probe("R5 no-rom", 16'h0000, 1'b0, 1'b0);
        sweep("R3", 1'b0, 1'b0);

        // R1: reset restores overlay and bank 0
        bus_cycle(16'h0030, 8'h01, 1'b0, 1'b1, 1'b1, 1'b0);
        do_reset();
        mem_probe("R1 rereset", 16'h0000, 1'b1, 1'b0);
        mem_probe("R1 rereset", 16'hC000, 1'b1, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule